// File: doc/BRIEF.md
# Bang-Bang Proportional-Integral Loop Filter

This block is the digital loop filter of an all-digital clock generator, used once a coarse search has already fixed the oscillator code. Each enabled clock cycle it receives one early/late decision from a bang-bang phase detector. It turns those decisions into a tuning word for the oscillator. The word is the sum of a slow integral code and a fast proportional kick.

The proportional kick is several times larger than the integral step and lasts only for the cycle that follows its decision. The integral code is decimated. A signed counter gathers the decisions, and the integral code moves by one small step only when that counter reaches a net count of four in one direction. The counter then restarts from zero. As a result, noisy or alternating decisions never disturb the integral code, which keeps quantization noise low.

A load strobe seeds the integral code with the search result and drops any partial count. Both the integral code and the output word are held inside the 10-bit code range.

Top module: `bb_pi_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `tune_word` equals RESET_CODE (default 512), and the decision counter starts at zero.
- R2: A cycle with `load` high sets `tune_word` to `load_code` on the next cycle. It clears the decision counter and overrides any decision presented in the same cycle.
- R3: When `en` is high and `load` is low, `dir_up`=1 adds KP (default 4) to the integral code in the next cycle's `tune_word`, and `dir_up`=0 subtracts KP. The kick lasts one cycle only.
- R4: The integral code rises by KI (default 1) when the net count of up decisions reaches +4. It falls by KI when the count reaches -4. The counter returns to zero in the same cycle.
- R5: Decisions that never build a net count of four, such as strictly alternating ones, leave the integral code unchanged. The counter always stays strictly between -4 and +4.
- R6: `tune_word` is the integral code plus the proportional term, clamped to the range 0 to 1023.
- R7: The integral code saturates at 0 and at 1023 and never wraps around.
- R8: A cycle with `en` and `load` both low leaves the integral code and the counter unchanged, and the next `tune_word` equals the integral code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Seed strobe from the coarse search |
| load_code | input | 10 | Code found by the coarse search |
| en | input | 1 | Decision is valid this cycle |
| dir_up | input | 1 | Detector decision: 1 raises the code, 0 lowers it |
| tune_word | output | 10 | Oscillator tuning word |

## Verification
Two functions can coincide in one cycle. The first case is a load strobe together with a valid decision: the bench raises `load` and `en` in the same cycle, both right after a partial count of three, and expects the loaded code with no kick and no later step until four fresh decisions arrive. The second case is an integral step together with the output clamp. The bench seeds codes next to 0 and 1023 and pushes decisions past the limits, and a behavioural model judges every cycle.

// File: rtl/bb_pi_filter.sv
module bb_pi_filter #(
  parameter int W          = 10,
  parameter int KP         = 4,
  parameter int KI         = 1,
  parameter int DEC        = 4,
  parameter int RESET_CODE = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_code,
  input  logic         en,
  input  logic         dir_up,
  output logic [W-1:0] tune_word
);

  localparam int CW = $clog2(DEC) + 2;
  localparam int SW = W + 2;
  localparam logic signed [CW-1:0] C_ONE  = CW'(1);
  localparam logic signed [CW-1:0] C_MONE = CW'(-1);
  localparam logic signed [CW-1:0] DEC_S  = CW'(DEC);
  localparam logic signed [CW-1:0] NDEC_S = CW'(-DEC);
  localparam logic signed [SW-1:0] KP_S   = SW'(KP);
  localparam logic signed [SW-1:0] KI_S   = SW'(KI);
  localparam logic signed [SW-1:0] MAX_S  = SW'((1 << W) - 1);
  localparam logic signed [SW-1:0] ZERO_S = '0;

  logic [W-1:0]           integ_q, integ_d;
  logic signed [CW-1:0]   cnt_q, cnt_d, cnt_sum;
  logic signed [SW-1:0]   prop_q, prop_d;
  logic signed [SW-1:0]   integ_ext, inc_v, dec_v, out_sum;

  assign integ_ext = signed'({2'b00, integ_q});
  assign cnt_sum   = cnt_q + (dir_up ? C_ONE : C_MONE);
  assign inc_v     = integ_ext + KI_S;
  assign dec_v     = integ_ext - KI_S;
  assign out_sum   = integ_ext + prop_q;

  always_comb begin
    integ_d = integ_q;
    cnt_d   = cnt_q;
    prop_d  = ZERO_S;
    if (load) begin
      integ_d = load_code;
      cnt_d   = '0;
    end else if (en) begin
      prop_d = dir_up ? KP_S : -KP_S;
      if (cnt_sum >= DEC_S) begin
        cnt_d   = '0;
        integ_d = (inc_v > MAX_S) ? W'(MAX_S) : W'(inc_v);
      end else if (cnt_sum <= NDEC_S) begin
        cnt_d   = '0;
        integ_d = (dec_v < ZERO_S) ? '0 : W'(dec_v);
      end else begin
        cnt_d = cnt_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= W'(RESET_CODE);
      cnt_q   <= '0;
      prop_q  <= '0;
    end else begin
      integ_q <= integ_d;
      cnt_q   <= cnt_d;
      prop_q  <= prop_d;
    end
  end

  assign tune_word = (out_sum > MAX_S) ? W'(MAX_S) :
                     (out_sum < ZERO_S) ? '0 : W'(out_sum);

  // R2
  assert_load_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tune_word == $past(load_code) && cnt_q == '0));

  // R3
  assert_kick_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && dir_up) |=> (tune_word >= integ_q));
  assert_kick_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !dir_up) |=> (tune_word <= integ_q));

  // R4
  assert_small_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((integ_ext - $past(integ_ext)) <= KI_S &&
               ($past(integ_ext) - integ_ext) <= KI_S));

  // R5
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < DEC_S && cnt_q > NDEC_S));

  // R8
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> ($stable(integ_q) && $stable(cnt_q) && tune_word == integ_q));

endmodule

// File: tb/tb_bb_pi_filter.sv
module tb_bb_pi_filter;
  localparam int PERIOD = 10;
  localparam int KP = 4;
  localparam int KI = 1;
  localparam int MAXC = 1023;

  logic clk = 0, rst_n = 0, load = 0, en = 0, dir_up = 0;
  logic [9:0] load_code = '0;
  logic [9:0] tune_word;

  int checks = 0, fails = 0;
  int m_int = 512, m_cnt = 0, m_prop = 0;
  bit done = 0;

  bb_pi_filter dut (.clk(clk), .rst_n(rst_n), .load(load), .load_code(load_code),
                    .en(en), .dir_up(dir_up), .tune_word(tune_word));

  always #(PERIOD/2) clk = ~clk;

  function automatic int clampc(int v);
    return (v > MAXC) ? MAXC : (v < 0 ? 0 : v);
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (int'(tune_word) != exp) begin
      fails++;
      $display("FAIL %s: tune_word=%0d expected=%0d", tag, tune_word, exp);
    end
  endtask

  task automatic step(string tag, bit ld, int code, bit e, bit up);
    int d;
    load = ld; load_code = 10'(code); en = e; dir_up = up;
    @(posedge clk);
    if (ld) begin
      m_int = code; m_cnt = 0; m_prop = 0;
    end else if (e) begin
      d = up ? 1 : -1;
      m_cnt += d;
      m_prop = d * KP;
      if (m_cnt >= 4) begin m_int = clampc(m_int + KI); m_cnt = 0; end
      else if (m_cnt <= -4) begin m_int = clampc(m_int - KI); m_cnt = 0; end
    end else m_prop = 0;
    @(negedge clk);
    check(tag, clampc(m_int + m_prop));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    #(PERIOD*2 + 1);
    check("R1 in reset", 512);
    @(negedge clk); rst_n = 1;
    step("R1 after reset idle", 0, 0, 0, 0);
    step("R2 load 100", 1, 100, 0, 0);
    step("R3 up kick", 0, 0, 1, 1);
    step("R3 kick gone", 0, 0, 0, 0);
    step("R3 down kick", 0, 0, 1, 0);
    step("R8 idle", 0, 0, 0, 0);
    step("R2 reload 100", 1, 100, 0, 0);
    for (int i = 0; i < 4; i++) step("R4 four ups", 0, 0, 1, 1);
    step("R4 stepped to 101", 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R4 four downs", 0, 0, 1, 0);
    step("R4 back to 100", 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step("R5 alternating", 0, 0, 1, i[0]);
    step("R5 integral unchanged", 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R8 partial ups", 0, 0, 1, 1);
    for (int i = 0; i < 5; i++) step("R8 idle holds count", 0, 0, 0, 0);
    step("R8 fourth up after idle", 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) step("R2 partial before load", 0, 0, 1, 1);
    step("R2 load with decision", 1, 300, 1, 1);
    for (int i = 0; i < 3; i++) step("R2 count cleared", 0, 0, 1, 1);
    step("R2 fourth after load", 0, 0, 1, 1);
    step("R6 load near top", 1, 1021, 0, 0);
    step("R6 clamp high", 0, 0, 1, 1);
    for (int i = 0; i < 12; i++) step("R7 saturate high", 0, 0, 1, 1);
    step("R7 held at 1023", 0, 0, 0, 0);
    step("R6 load near bottom", 1, 2, 0, 0);
    step("R6 clamp low", 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) step("R7 saturate low", 0, 0, 1, 0);
    step("R7 held at 0", 0, 0, 0, 0);
    step("R2 load mid", 1, 512, 0, 0);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4 mixed pattern", (lfsr[7:0] == 8'h3C), int'(lfsr[12:3]), lfsr[1] | lfsr[5], lfsr[0] | lfsr[9]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule